// File: doc/BRIEF.md
# Buffered Down-Counting Timer Bank

The block holds five independent down-counters that share one register port. Each channel has a count buffer and, except for the last channel, a compare buffer. A channel does nothing with these buffers until software raises the channel's manual-update bit. While that bit is high, the buffers are copied into the live counter and the live compare value. Software then clears manual update and sets start in a single control write. It picks one-shot or auto-reload operation with the channel's auto-reload bit.

Each cycle in which a channel's tick enable is high moves a running counter one step toward zero. The tick that arrives while the counter already holds zero is the expiry. On expiry the channel raises a sticky status flag and either reloads from its count buffer or stops. A PWM level compares the live count with the live compare value, with an optional inversion. A read-only observation register per channel shows the live count. Software inverts this value to obtain a rising timebase.

Top module: `dctimer_bank`

## Requirements
- R1: The register map is fixed. The count buffer of channel c sits at 0x0C+12c and the compare buffer at 0x10+12c, for c from 0 to 3 only. The observation register sits at 0x14+12c, except for channel 4, whose observation register is at 0x40. A write with bus_we stores the low CNT_W bits of bus_wdata. When bus_re is high, bus_rdata returns the addressed value one clock later, zero-extended. Unmapped addresses read 0.
- R2: The control register is at 0x08. Channel 0 owns bits [3:0]. Channel c≥1 owns bits [4c+7:4c+4], so bits [7:4] are unused and read 0. Within a group, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. Channel 4 has auto-reload at bit 2 of its group and no invert, so bit 23 reads 0.
- R3: While a channel's manual-update bit is set, each clock copies the count buffer into the live counter and the compare buffer into the live compare value, and ticks are ignored.
- R4: A started channel decrements its counter by one on each clock where its tick enable is high. With a count buffer of N, expiry happens on tick N+1, the tick taken at zero.
- R5: At expiry with auto-reload set, the counter reloads N and keeps running.
- R6: At expiry with auto-reload clear, the counter stays at 0 and the channel's start bit reads back 0.
- R7: The interrupt register is at 0x44. Bits [4:0] are enables and bits [9:5] are status flags for channels 0 to 4. Expiry sets the channel's flag. Writing 1 to a flag bit clears it, writing 0 leaves it unchanged, and a simultaneous expiry wins.
- R8: Output irq[c] is high exactly while the status flag and enable bit of channel c are both set. It rises on the clock edge of the expiry.
- R9: Clearing start freezes the counter. Setting start again resumes from the frozen value, and no reload happens unless manual update is also set.
- R10: One clock after the live state changes, pwm[c] equals (live count > live compare) XOR invert.
- R11: Channel 4 compares against a fixed value of 0 and is never inverted, so pwm[4] is high exactly while its count is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 5 | Per-channel count enable, one step per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one clock after bus_re |
| irq | output | 5 | Per-channel interrupt, status AND enable |
| pwm | output | 5 | Per-channel registered PWM level |

## Verification
The assertions assume that tick enables may take any pattern. A tick that arrives while manual update is high is taken as lost, not counted. They also assume that software can rewrite the control register at any time, so a one-shot stop is judged by the control state the counter saw, never by a write that lands on the same edge. The stimulus issues bus accesses and ticks in turn, never together. This keeps every expected count a plain function of the number of ticks the bench has delivered. The random phase only draws buffer values, modes and tick counts. Between draws it restarts the channel through manual update, so each draw starts from a known load.

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;
  localparam int NCH    = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int CTRL_W = 4 * (NCH + 1);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_IRQ  = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_OBS_LAST = 8'h40;

  // control group base: a one-group hole follows channel 0
  function automatic int grp_lsb(int c);
    return (c == 0) ? 0 : 4 * (c + 1);
  endfunction

  function automatic int start_pos(int c);
    return grp_lsb(c);
  endfunction

  function automatic int upd_pos(int c);
    return grp_lsb(c) + 1;
  endfunction

  function automatic int inv_pos(int c);
    return grp_lsb(c) + 2;
  endfunction

  function automatic int arl_pos(int c);
    return (c == NCH - 1) ? grp_lsb(c) + 2 : grp_lsb(c) + 3;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[start_pos(c)] = 1'b1;
      m[upd_pos(c)]   = 1'b1;
      m[arl_pos(c)]   = 1'b1;
      if (c != NCH - 1) m[inv_pos(c)] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] cntb_addr(int c);
    return ADDR_W'(12 + 12 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] cmpb_addr(int c);
    return ADDR_W'(16 + 12 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] obs_addr(int c);
    return (c == NCH - 1) ? ADDR_OBS_LAST : ADDR_W'(20 + 12 * c);
  endfunction
endpackage

// File: rtl/dctimer_chan.sv
module dctimer_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             upd,
  input  logic             arl,
  input  logic             inv,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             pwm_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = run && tick && !upd && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_buf;
      cmp_q <= cmp_buf;
    end else if (run && tick) begin
      if (!at_zero)  cnt_q <= cnt_q - 1'b1;
      else if (arl)  cnt_q <= cnt_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= (cnt_q > cmp_q) ^ inv;
  end

  assign cnt = cnt_q;
  assign pwm = pwm_q;
endmodule

// File: rtl/dctimer_regs.sv
module dctimer_regs
  import dctimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic                       re,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic [NCH-1:0]             expire,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt_live,
  output logic [NCH-1:0]             run,
  output logic [NCH-1:0]             upd,
  output logic [NCH-1:0]             arl,
  output logic [NCH-1:0]             inv,
  output logic [NCH-1:0][CNT_W-1:0]  cnt_buf,
  output logic [NCH-1:0][CNT_W-1:0]  cmp_buf,
  output logic [NCH-1:0]             status,
  output logic [NCH-1:0]             irq
);
  localparam logic [CTRL_W-1:0] CTRL_MASK = ctrl_mask();

  logic [CTRL_W-1:0]            ctrl_q, ctrl_d;
  logic [NCH-1:0][CNT_W-1:0]    cntb_q, cmpb_q;
  logic [NCH-1:0]               ien_q, ien_d, ist_q, ist_d, irq_q;
  logic [DATA_W-1:0]            rd_mux, rdata_q;
  logic                         wr_ctrl, wr_irq;
  logic                         unused_bits;

  assign unused_bits = ^wdata[DATA_W-1:CTRL_W];
  assign wr_ctrl = we && (addr == ADDR_CTRL);
  assign wr_irq  = we && (addr == ADDR_IRQ);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = wdata[CTRL_W-1:0] & CTRL_MASK;
    for (int c = 0; c < NCH; c++)
      if (expire[c] && !ctrl_q[arl_pos(c)]) ctrl_d[start_pos(c)] = 1'b0;
  end

  always_comb begin
    ien_d = ien_q;
    ist_d = ist_q;
    if (wr_irq) begin
      ien_d = wdata[NCH-1:0];
      ist_d = ist_q & ~wdata[2*NCH-1:NCH];
    end
    ist_d = ist_d | expire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      ist_q  <= '0;
      irq_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
      ist_q  <= ist_d;
      irq_q  <= ist_d & ien_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntb_q <= '0;
      cmpb_q <= '0;
    end else if (we) begin
      for (int c = 0; c < NCH; c++) begin
        if (addr == cntb_addr(c)) cntb_q[c] <= wdata[CNT_W-1:0];
        if (c != NCH - 1 && addr == cmpb_addr(c)) cmpb_q[c] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_CTRL) rd_mux[CTRL_W-1:0] = ctrl_q;
    if (addr == ADDR_IRQ)  rd_mux[2*NCH-1:0] = {ist_q, ien_q};
    for (int c = 0; c < NCH; c++) begin
      if (addr == cntb_addr(c)) rd_mux[CNT_W-1:0] = cntb_q[c];
      if (c != NCH - 1 && addr == cmpb_addr(c)) rd_mux[CNT_W-1:0] = cmpb_q[c];
      if (addr == obs_addr(c)) rd_mux[CNT_W-1:0] = cnt_live[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= rd_mux;
    else         rdata_q <= '0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_fields
    assign run[c] = ctrl_q[start_pos(c)];
    assign upd[c] = ctrl_q[upd_pos(c)];
    assign arl[c] = ctrl_q[arl_pos(c)];
    if (c == NCH - 1) begin : g_noinv
      assign inv[c] = 1'b0;
    end else begin : g_inv
      assign inv[c] = ctrl_q[inv_pos(c)];
    end
  end

  assign cnt_buf = cntb_q;
  assign cmp_buf = cmpb_q;
  assign status  = ist_q;
  assign irq     = irq_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/dctimer_bank.sv
module dctimer_bank
  import dctimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    tick_en,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    pwm
);
  logic [NCH-1:0]            run_w, upd_w, arl_w, inv_w, exp_w, ist_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_w, cntb_w, cmpb_w;

  dctimer_regs #(.CNT_W(CNT_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .re       (bus_re),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .expire   (exp_w),
    .cnt_live (cnt_w),
    .run      (run_w),
    .upd      (upd_w),
    .arl      (arl_w),
    .inv      (inv_w),
    .cnt_buf  (cntb_w),
    .cmp_buf  (cmpb_w),
    .status   (ist_w),
    .irq      (irq)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dctimer_chan #(.CNT_W(CNT_W)) chan_i (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick_en[c]),
      .run     (run_w[c]),
      .upd     (upd_w[c]),
      .arl     (arl_w[c]),
      .inv     (inv_w[c]),
      .cnt_buf (cntb_w[c]),
      .cmp_buf (cmpb_w[c]),
      .cnt     (cnt_w[c]),
      .expire  (exp_w[c]),
      .pwm     (pwm[c])
    );
  end
endmodule

// File: rtl/dctimer_bank_chk.sv
module dctimer_bank_chk
  import dctimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0]            tick_en,
  input logic [NCH-1:0]            run_w,
  input logic [NCH-1:0]            upd_w,
  input logic [NCH-1:0]            arl_w,
  input logic [NCH-1:0][CNT_W-1:0] cnt_w,
  input logic [NCH-1:0][CNT_W-1:0] cntb_w,
  input logic [NCH-1:0]            ist_w
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic at_exp;
    assign at_exp = run_w[c] && tick_en[c] && !upd_w[c] && (cnt_w[c] == '0);

    AST_UPD_LOAD: assert property (@(posedge clk) disable iff (rst)
      upd_w[c] |=> cnt_w[c] == $past(cntb_w[c])); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (run_w[c] && tick_en[c] && !upd_w[c] && cnt_w[c] != '0)
        |=> cnt_w[c] == $past(cnt_w[c]) - 1'b1); // R4

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (at_exp && arl_w[c]) |=> cnt_w[c] == $past(cntb_w[c])); // R5

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
      (at_exp && !arl_w[c]) |=> (!run_w[c] && cnt_w[c] == '0)); // R6

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (rst)
      at_exp |=> ist_w[c]); // R7

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (!run_w[c] && !upd_w[c]) |=> $stable(cnt_w[c])); // R9
  end
endmodule

bind dctimer_bank dctimer_bank_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .tick_en (tick_en),
  .run_w   (run_w),
  .upd_w   (upd_w),
  .arl_w   (arl_w),
  .cnt_w   (cnt_w),
  .cntb_w  (cntb_w),
  .ist_w   (ist_w)
);

// File: tb/dctimer_bank_tb_top.sv
module dctimer_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam logic [31:0] CMASK = (32'h1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  tick_en = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  irq, pwm;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dctimer_bank #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .pwm(pwm)
  );

  // control word built from the layout stated in R2
  function automatic logic [31:0] cw(int c, bit st, bit up, bit ar, bit iv);
    int g;
    logic [31:0] w;
    g = (c == 0) ? 0 : 4 * (c + 1);
    w = '0;
    w[g] = st;
    w[g+1] = up;
    if (c == 4) w[g+2] = ar;
    else begin w[g+2] = iv; w[g+3] = ar; end
    return w;
  endfunction

  function automatic logic [31:0] a_cnt(int c); return 32'h0C + 12 * c; endfunction
  function automatic logic [31:0] a_cmp(int c); return 32'h10 + 12 * c; endfunction
  function automatic logic [31:0] a_obs(int c); return (c == 4) ? 32'h40 : 32'h14 + 12 * c; endfunction

  // expected live count after t ticks from a fresh load of n
  function automatic logic [31:0] exp_cnt(int n, int t, bit ar);
    if (ar) return n - (t % (n + 1));
    return (t <= n) ? n - t : 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a[7:0]; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a[7:0];
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(int c, int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      tick_en[c] = 1'b1;
      @(negedge clk);
      tick_en[c] = 1'b0;
    end
  endtask

  task automatic load(int c, int n, bit ar, bit iv);
    wr(a_cnt(c), n);
    wr(32'h08, cw(c, 0, 1, ar, iv));
    wr(32'h08, cw(c, 1, 0, ar, iv));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    int n, k;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(32'h08, d); chk("R2 reset ctrl", d, 0);
    rd(32'h44, d); chk("R7 reset irq reg", d, 0);
    rd(a_obs(0), d); chk("R1 reset obs", d, 0);
    chk("R8 reset irq", irq, 0);
    chk("R10 reset pwm", pwm, 0);

    // R1 buffer map and readback
    for (int c = 0; c < 5; c++) begin
      v = $urandom();
      wr(a_cnt(c), v);
      rd(a_cnt(c), d); chk("R1 count buffer", d, v & CMASK);
      if (c < 4) begin
        v = $urandom();
        wr(a_cmp(c), v);
        rd(a_cmp(c), d); chk("R1 compare buffer", d, v & CMASK);
      end
    end
    rd(32'h00, d); chk("R1 unmapped", d, 0);

    // R2 control layout: gap and missing ch4 invert
    wr(32'h08, 32'hFFFF_FFFF);
    rd(32'h08, d); chk("R2 writable bits", d, 32'h007F_FF0F);
    wr(32'h08, 0);

    // R3 / R4 / R6 / R8 one-shot on channel 1
    n = $urandom_range(3, 12);
    wr(32'h44, 32'h2);
    load(1, n, 0, 0);
    rd(a_obs(1), d); chk("R3 manual load", d, n);
    k = $urandom_range(1, n - 1);
    tick(1, k);
    rd(a_obs(1), d); chk("R4 partial count", d, n - k);
    tick(1, n - k);
    rd(a_obs(1), d); chk("R4 at zero", d, 0);
    chk("R4 no expiry at N ticks", irq[1], 0);
    tick(1, 1);
    chk("R8 irq on expiry", irq[1], 1);
    rd(32'h44, d); chk("R7 status bit", d, 32'h42);
    rd(32'h08, d); chk("R6 start cleared", d, 0);
    tick(1, 3);
    rd(a_obs(1), d); chk("R6 stays zero", d, 0);
    wr(32'h44, 32'h2);
    rd(32'h44, d); chk("R7 write 0 keeps", d, 32'h42);
    wr(32'h44, 32'h42);
    rd(32'h44, d); chk("R7 write 1 clears", d, 32'h2);
    chk("R8 irq drops", irq[1], 0);

    // R5 auto-reload on channel 2, interrupt disabled
    wr(32'h44, 0);
    n = $urandom_range(2, 6);
    load(2, n, 1, 0);
    for (int p = 0; p < 3; p++) begin
      tick(2, n + 1);
      rd(a_obs(2), d); chk("R5 reloaded", d, n);
      rd(32'h44, d); chk("R7 status ch2", d, 32'h80);
      chk("R8 irq masked", irq[2], 0);
      wr(32'h44, 32'h80);
    end

    // R9 freeze and resume
    tick(2, 1);
    wr(32'h08, cw(2, 0, 0, 1, 0));
    tick(2, 3);
    rd(a_obs(2), d); chk("R9 frozen", d, n - 1);
    wr(32'h08, cw(2, 1, 0, 1, 0));
    tick(2, 1);
    rd(a_obs(2), d); chk("R9 resume no reload", d, n - 2);
    wr(a_cnt(2), 40);
    wr(32'h08, cw(2, 1, 1, 1, 0));
    tick(2, 2);
    rd(a_obs(2), d); chk("R3 ticks ignored in update", d, 40);
    wr(32'h08, 0);

    // R10 PWM on channel 0
    wr(a_cmp(0), 4);
    load(0, 10, 1, 0);
    repeat (2) @(negedge clk);
    chk("R10 above compare", pwm[0], 1);
    tick(0, 6);
    repeat (2) @(negedge clk);
    chk("R10 equal compare", pwm[0], 0);
    wr(32'h08, cw(0, 1, 0, 1, 1));
    repeat (2) @(negedge clk);
    chk("R10 inverted", pwm[0], 1);
    wr(32'h08, 0);

    // R11 / R2 channel 4: auto-reload bit at group bit 2, obs at 0x40
    load(4, 5, 1, 0);
    rd(32'h40, d); chk("R1 ch4 observation", d, 5);
    repeat (2) @(negedge clk);
    chk("R11 ch4 pwm nonzero", pwm[4], 1);
    tick(4, 6);
    rd(32'h40, d); chk("R2 ch4 auto-reload bit", d, 5);
    rd(32'h44, d); chk("R7 ch4 status bit 9", d, 32'h200);
    wr(32'h44, 32'h200);
    wr(32'h08, cw(4, 0, 0, 1, 0));
    load(4, 1, 0, 0);
    tick(4, 1);
    repeat (2) @(negedge clk);
    chk("R11 ch4 pwm zero", pwm[4], 0);
    wr(32'h08, 0);

    // R4 boundary: count buffer 0 expires on every tick
    wr(32'h44, 32'h3E0);
    load(3, 0, 1, 0);
    tick(3, 1);
    chk("R4 zero-length expiry", irq[3], 0);
    rd(32'h44, d); chk("R4 zero-length status", d, 32'h100);

    // random draws on channel 3
    for (int it = 0; it < 20; it++) begin
      bit ar;
      int t;
      wr(32'h08, 0);
      wr(32'h44, 32'h3E8);
      n = $urandom_range(0, 20);
      ar = 1'($urandom_range(0, 1));
      t = $urandom_range(0, 2 * n + 2);
      load(3, n, ar, 0);
      tick(3, t);
      rd(a_obs(3), d); chk(ar ? "R5 random count" : "R6 random count", d, exp_cnt(n, t, ar));
      chk("R8 random irq", irq[3], (t > n) ? 1 : 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule